// File: doc/BRIEF.md
# DMA Descriptor Table Builder

This block turns a single storage transfer request, given as a starting byte address and a number of 512-byte blocks, into the descriptor table that a bus-master DMA engine walks. Each descriptor is an 8-byte pair: a 32-bit base address and a 32-bit count word. The block writes one descriptor per clock cycle to a small descriptor memory through a write port that carries the slot index, the address and the count word. No descriptor spans a 64 KiB address boundary. The descriptor that holds the last bytes of the transfer has its end-of-table flag set.

Before it writes anything, the block checks the request. It refuses a request that starts at an odd byte address, a request of zero blocks, and a request that would need more than the descriptor limit (16 by default). A refused request gives a one-cycle error pulse and causes no writes, so the caller can switch to programmed I/O. A request that is accepted ends with a one-cycle done pulse and the number of descriptors written.

Top module: `dma_desc_splitter`

## Requirements
- R1: While reset is asserted and right after it, `busy`, `wr_en`, `done` and `error` are all low.
- R2: The transfer length in bytes is `req_blocks` times 512.
- R3: A request whose `req_addr[0]` is 1 is refused. `error` pulses high for one cycle, in the cycle after acceptance, and `wr_en` stays low.
- R4: A request with `req_blocks` equal to 0 is refused in the same way as in R3, with no descriptor written.
- R5: A request that would need more than 16 descriptors is refused in the same way as in R3, with no descriptor written. A request that needs exactly 16 descriptors is accepted.
- R6: The byte count of each descriptor is the smaller of the bytes still remaining and 0x10000 minus the low 16 bits of that descriptor's address. As a result, no descriptor crosses a 64 KiB boundary.
- R7: Descriptors go to slots 0, 1, 2 and so on, one per cycle, with no gaps. The first slot gets `req_addr`. Each later descriptor's address is the previous address plus the previous byte count.
- R8: The count word holds the byte count in bits 16:0, so a full 64 KiB chunk is written plainly as 0x10000. Bits 30:17 are zero. Bit 31 is 1 only on the last descriptor.
- R9: `done` pulses high for one cycle, in the cycle after the last descriptor is written. While it is high, `entry_total` equals the number of descriptors written. `done`, `error` and `wr_en` are never high together.
- R10: `req_valid` is ignored while `busy` is high. A request presented during emission changes none of the descriptors being written.
- R11: Slot 0 is written in the cycle right after the request is accepted (`req_valid` high while idle).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_addr | input | ADDR_W | Starting byte address |
| req_blocks | input | BLKS_W | Number of 512-byte blocks |
| busy | output | 1 | High while descriptors are being emitted |
| wr_en | output | 1 | Descriptor write strobe |
| wr_idx | output | IDX_W | Descriptor slot index |
| wr_addr | output | ADDR_W | Descriptor base address |
| wr_word | output | 32 | Count word: end flag in bit 31, byte count in bits 16:0 |
| done | output | 1 | One-cycle pulse when the table is complete |
| error | output | 1 | One-cycle pulse when a request is refused |
| entry_total | output | NUM_W | Number of descriptors written by the last request (0 after a refusal) |

## Verification
The assertions assume that a descriptor's address plus its byte count does not wrap past the top of the 32-bit address space. They check address chaining and boundary containment with plain modular arithmetic, so a wrapping request would produce confusing results rather than a design error. To stay within that assumption, the random stimulus keeps start addresses below 0x1000_0000. It also keeps block counts small enough that the range never approaches the top of memory. The directed cases that exercise the boundary start at or near 64 KiB multiples in low memory. The stimulus deliberately drives `req_valid` high during emission, which is legal, because R10 requires the block to ignore it.

// File: rtl/dds_pkg.sv
package dds_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } state_e;

    localparam int WORD_W  = 32;
    localparam int END_BIT = 31;
endpackage

// File: rtl/dds_req_check.sv
module dds_req_check #(
    parameter int ADDR_W      = 32,
    parameter int BLKS_W      = 16,
    parameter int BLK_BYTES   = 512,
    parameter int MAX_ENTRIES = 16,
    parameter int SEG_W       = 16,
    parameter int LEN_W       = BLKS_W + $clog2(BLK_BYTES)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [BLKS_W-1:0] blocks,
    output logic [LEN_W-1:0]  len,
    output logic              reject
);
    localparam int HI_W   = ADDR_W + 1 - SEG_W;
    localparam int NEED_W = HI_W + 1;

    // Length: a shift when the block size is a power of two, else a multiply.
    generate
        if ((BLK_BYTES & (BLK_BYTES - 1)) == 0) begin : g_shift
            assign len = LEN_W'(blocks) << $clog2(BLK_BYTES);
        end else begin : g_mult
            assign len = LEN_W'(blocks) * LEN_W'(BLK_BYTES);
        end
    endgenerate

    logic [ADDR_W:0]   last_byte;
    logic [HI_W-1:0]   seg_first;
    logic [HI_W-1:0]   seg_last;
    logic [NEED_W-1:0] need;

    always_comb begin
        last_byte = {1'b0, addr} + (ADDR_W+1)'(len) - (ADDR_W+1)'(1);
        seg_last  = last_byte[ADDR_W:SEG_W];
        seg_first = HI_W'(addr[ADDR_W-1:SEG_W]);
        need      = NEED_W'(seg_last - seg_first) + NEED_W'(1);
        reject    = addr[0]
                  | (len == '0)
                  | (need > NEED_W'(MAX_ENTRIES));
    end
endmodule

// File: rtl/dds_chunk_calc.sv
module dds_chunk_calc #(
    parameter int SEG_W = 16,
    parameter int LEN_W = 25
) (
    input  logic [SEG_W-1:0] seg_off,
    input  logic [LEN_W-1:0] remain,
    output logic [SEG_W:0]   chunk,
    output logic             last
);
    localparam int CMP_W = (LEN_W > SEG_W + 1) ? LEN_W : SEG_W + 1;

    logic [SEG_W:0]   room;
    logic [CMP_W-1:0] room_x;
    logic [CMP_W-1:0] rem_x;

    always_comb begin
        room   = ((SEG_W+1)'(1) << SEG_W) - (SEG_W+1)'(seg_off);
        room_x = CMP_W'(room);
        rem_x  = CMP_W'(remain);
        last   = (rem_x <= room_x);
        chunk  = last ? rem_x[SEG_W:0] : room;
    end
endmodule

// File: rtl/dma_desc_splitter.sv
module dma_desc_splitter #(
    parameter int ADDR_W      = 32,
    parameter int BLKS_W      = 16,
    parameter int BLK_BYTES   = 512,
    parameter int MAX_ENTRIES = 16,
    parameter int SEG_W       = 16,
    localparam int IDX_W      = (MAX_ENTRIES > 1) ? $clog2(MAX_ENTRIES) : 1,
    localparam int NUM_W      = $clog2(MAX_ENTRIES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BLKS_W-1:0] req_blocks,
    output logic              busy,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [31:0]       wr_word,
    output logic              done,
    output logic              error,
    output logic [NUM_W-1:0]  entry_total
);
    import dds_pkg::*;

    localparam int LEN_W = BLKS_W + $clog2(BLK_BYTES);
    localparam int PAD_W = WORD_W - 1 - (SEG_W + 1);

    typedef struct packed {
        state_e            state;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  remain;
        logic [IDX_W-1:0]  idx;
        logic              done;
        logic              error;
        logic [NUM_W-1:0]  total;
    } regs_t;

    regs_t q, d;

    logic [LEN_W-1:0] req_len;
    logic             req_reject;
    logic [SEG_W:0]   chunk;
    logic             is_last;

    dds_req_check #(
        .ADDR_W(ADDR_W), .BLKS_W(BLKS_W), .BLK_BYTES(BLK_BYTES),
        .MAX_ENTRIES(MAX_ENTRIES), .SEG_W(SEG_W), .LEN_W(LEN_W)
    ) u_check (
        .addr   (req_addr),
        .blocks (req_blocks),
        .len    (req_len),
        .reject (req_reject)
    );

    dds_chunk_calc #(
        .SEG_W(SEG_W), .LEN_W(LEN_W)
    ) u_chunk (
        .seg_off (q.addr[SEG_W-1:0]),
        .remain  (q.remain),
        .chunk   (chunk),
        .last    (is_last)
    );

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        d.error = 1'b0;
        case (q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    if (req_reject) begin
                        d.error = 1'b1;
                        d.total = '0;
                    end else begin
                        d.state  = ST_EMIT;
                        d.addr   = req_addr;
                        d.remain = req_len;
                        d.idx    = '0;
                    end
                end
            end
            ST_EMIT: begin
                d.addr   = q.addr + ADDR_W'(chunk);
                d.remain = q.remain - LEN_W'(chunk);
                d.idx    = q.idx + IDX_W'(1);
                if (is_last) begin
                    d.state = ST_IDLE;
                    d.done  = 1'b1;
                    d.total = NUM_W'(q.idx) + NUM_W'(1);
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.state  <= ST_IDLE;
            q.addr   <= '0;
            q.remain <= '0;
            q.idx    <= '0;
            q.done   <= 1'b0;
            q.error  <= 1'b0;
            q.total  <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy        = (q.state != ST_IDLE);
    assign wr_en       = (q.state == ST_EMIT);
    assign wr_idx      = q.idx;
    assign wr_addr     = q.addr;
    assign wr_word     = {is_last, {PAD_W{1'b0}}, chunk};
    assign done        = q.done;
    assign error       = q.error;
    assign entry_total = q.total;
endmodule

// File: rtl/dds_checker.sv
module dds_checker #(
    parameter int ADDR_W = 32,
    parameter int SEG_W  = 16,
    parameter int IDX_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [IDX_W-1:0]  wr_idx,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [31:0]       wr_word,
    input logic              done,
    input logic              error
);
    localparam logic [SEG_W+1:0] SPAN = (SEG_W+2)'(1) << SEG_W;

    AST_NO_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ((SEG_W+2)'(wr_addr[SEG_W-1:0]) + (SEG_W+2)'(wr_word[SEG_W:0])) <= SPAN); // R6

    AST_WORD_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_word[SEG_W:0] != '0) && (wr_word[30:SEG_W+1] == '0)); // R8

    AST_EVEN_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !wr_addr[0]); // R3

    AST_ADDR_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en) && !$past(wr_word[31]))
        |-> wr_addr == $past(wr_addr) + ADDR_W'($past(wr_word[SEG_W:0]))); // R7

    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en) && !$past(wr_word[31]))
        |-> wr_idx == IDX_W'($past(wr_idx) + 1'b1)); // R7

    AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_word[31]) |=> done); // R9

    AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_en, done, error})); // R9
endmodule

bind dma_desc_splitter dds_checker #(
    .ADDR_W(ADDR_W), .SEG_W(SEG_W), .IDX_W(IDX_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_addr (wr_addr),
    .wr_word (wr_word),
    .done    (done),
    .error   (error)
);

// File: tb/dma_desc_splitter_tb.sv
module dma_desc_splitter_tb;
    localparam int CLK_PERIOD = 10;
    localparam int MAXN = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [15:0] req_blocks = '0;
    logic        busy, wr_en, done, error;
    logic [3:0]  wr_idx;
    logic [31:0] wr_addr, wr_word;
    logic [4:0]  entry_total;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    longint exp_addr [0:63];
    longint exp_word [0:63];
    int     exp_n;
    bit     exp_err;

    longint got_addr [0:63];
    longint got_word [0:63];
    int     got_idx  [0:63];
    int     got_n;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_desc_splitter u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_blocks(req_blocks), .busy(busy), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_addr(wr_addr), .wr_word(wr_word), .done(done), .error(error),
        .entry_total(entry_total)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Reference model built from R2, R3, R4, R5, R6 and R8
    function automatic void model(input longint a0, input longint blocks);
        longint a, rem, room, c;
        a = a0;
        rem = blocks * 512;
        exp_n = 0;
        exp_err = (a0[0] == 1'b1) || (rem == 0);
        while (!exp_err && rem > 0) begin
            room = 65536 - (a & 65535);
            c = (rem < room) ? rem : room;
            if (exp_n == MAXN) begin
                exp_err = 1;
                break;
            end
            exp_addr[exp_n] = a;
            exp_word[exp_n] = c | ((rem == c) ? 64'h8000_0000 : 64'h0);
            a = (a + c) & 64'hFFFF_FFFF;
            rem -= c;
            exp_n++;
        end
    endfunction

    task automatic run_req(input longint a0, input longint blocks, input bit junk);
        int cyc;
        longint sum, a;
        model(a0, blocks);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr = a0[31:0];
        req_blocks = blocks[15:0];
        @(negedge clk);
        req_valid = 1'b0;
        // R11: first slot (or refusal) right after acceptance
        check(exp_err ? (error && !wr_en) : (wr_en && wr_idx == 0 && !error),
              "R11 first cycle", {wr_en, error}, exp_err ? 1 : 2);
        got_n = 0;
        cyc = 0;
        while (!done && !error && cyc < 40) begin
            if (wr_en && got_n < 64) begin
                got_addr[got_n] = wr_addr;
                got_word[got_n] = wr_word;
                got_idx[got_n] = wr_idx;
                got_n++;
            end
            if (junk) begin // R10: request during emission
                req_valid = 1'b1;
                req_addr = $urandom & 32'h0FFF_FFFE;
                req_blocks = 16'($urandom_range(1, 300));
            end
            @(negedge clk);
            cyc++;
        end
        req_valid = 1'b0;
        if (exp_err) begin
            check(error && got_n == 0, "R3/R4/R5 refusal", got_n, 0);
            check(entry_total == 0, "R9 total after refusal", entry_total, 0);
        end else begin
            check(done && !error, "R9 done pulse", {done, error}, 2);
            check(entry_total == exp_n, "R9 entry_total", entry_total, exp_n);
            check(got_n == exp_n, "R7 entry count", got_n, exp_n);
            for (int i = 0; i < exp_n && i < got_n; i++) begin
                check(got_idx[i] == i, "R7 slot index", got_idx[i], i);
                check(got_addr[i] == exp_addr[i], "R7 address", got_addr[i], exp_addr[i]);
                check(got_word[i] == exp_word[i], "R6/R8 count word", got_word[i], exp_word[i]);
            end
            // R6/R2: rebuild the range from captured descriptors
            sum = 0;
            a = a0;
            for (int i = 0; i < got_n; i++) begin
                check(got_addr[i] == a, "R7 contiguity", got_addr[i], a);
                check(((got_addr[i] & 65535) + (got_word[i] & 32'h1FFFF)) <= 65536,
                      "R6 no boundary cross", got_addr[i], 0);
                sum += got_word[i] & 32'h1FFFF;
                a = (got_addr[i] + (got_word[i] & 32'h1FFFF)) & 64'hFFFF_FFFF;
            end
            check(sum == blocks * 512, "R2 total bytes", sum, blocks * 512);
            @(negedge clk);
            check(!done && !busy, "R9 done one cycle", {done, busy}, 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        check(!busy && !wr_en && !done && !error, "R1 in reset", {busy, wr_en, done, error}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !wr_en && !done && !error, "R1 after reset", {busy, wr_en, done, error}, 0);

        run_req(64'h0, 1, 0);               // R2 single block
        run_req(64'h0, 2048, 0);            // R5/R8 exactly 16 full 64 KiB entries
        run_req(64'h0, 2049, 0);            // R5 seventeen needed
        run_req(64'h2, 2048, 0);            // R5 misaligned start needs 17
        run_req(64'hFFFE, 1, 0);            // R6 split across boundary
        run_req(64'h3, 4, 0);               // R3 odd address
        run_req(64'h100, 0, 0);             // R4 zero length
        run_req(64'h1234_5678, 65535, 0);   // R5 huge
        run_req(64'h0003_FF00, 300, 1);     // R10 requests while busy

        for (int k = 0; k < 60; k++) begin
            longint a, b;
            a = $urandom & 32'h0FFF_FFFF;
            if ($urandom_range(0, 3) != 0) a = a & ~64'h1;
            b = (k % 7 == 0) ? 0 : $urandom_range(1, 2200);
            run_req(a, b, k[0]);
        end

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule